// File: doc/BRIEF.md
# Host Wake-Request Power Handshake

This block is a host-facing control register that coordinates waking an internal processor power domain. The host sets a wake-request bit, and the block raises a request to the power controller. It then reports clock-ready once the controller has acknowledged for a programmable settling time. Software uses a combined access-grant output, or reads the individual status bits, to decide when internal resources can be touched safely.

The same register word also shows the live sleep-entry warning from the power controller and the 3-bit power-save mode, and it decodes that mode into a 2-bit class. It also carries the synchronized state of an external RF-kill switch. Every change of that switch produces a one-cycle event pulse, which the interrupt logic can use.

Top module: `hs_wake_ctrl`

## Requirements
- R1: After a synchronous reset with all inputs low, the register reads 0 and `pwr_req`, `access_ok` and `rfkill_event` are 0.
- R2: A write changes only bit 3 (wake request) and bit 2 (init-done). A write of 1 to any other bit, including bit 0, has no effect on the readback.
- R3: `pwr_req` is 1 while wake request or init-done is set, and 0 when both are clear.
- R4: Clock-ready (read bit 0) stays 0 while init-done is 0, however long `pwr_ack` is held.
- R5: With init-done set and `pwr_ack` held, clock-ready rises after READY_DLY rising edges of `clk` that sample both high. The value is still 0 after READY_DLY-1 such edges.
- R6: Clock-ready falls in the same cycle that `pwr_ack` goes low, with no clock edge in between.
- R7: `access_ok` is 1 exactly when clock-ready is 1, wake request is 1 and `sleep_pending` is 0. Read bit 4 shows `sleep_pending` live.
- R8: Read bits 26:24 show `ps_mode` live. `ps_kind` decodes the mode as follows: 000→0 (none), 001→1 (MAC down), 010→2 (radio down), and every other value→3 (fault).
- R9: Read bit 27 shows `rfkill_pin` after a two-flop synchronizer: a change made after an edge appears after the second following edge.
- R10: `rfkill_event` pulses for exactly one cycle on each rising and each falling change of the synchronized RF-kill level. The pulse is coincident with the bit 27 change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register readback word |
| pwr_req | output | 1 | Wake request to the power controller |
| pwr_ack | input | 1 | Power controller acknowledge (domain powered) |
| sleep_pending | input | 1 | Domain is entering sleep |
| ps_mode | input | 3 | Encoded power-save mode from the controller |
| ps_kind | output | 2 | Decoded power-save class |
| rfkill_pin | input | 1 | Asynchronous RF-kill switch level |
| rfkill_event | output | 1 | One-cycle pulse on each RF-kill change |
| access_ok | output | 1 | Internal access currently permitted |

## Verification
The ready handshake is tried in three orders. In the first, the acknowledge arrives before init-done. In the second, init-done is set while the acknowledge is already held. In the third, the acknowledge is dropped and restored, and clock-ready is sampled one edge before and exactly at the settling count, so that an early or late rise can be told from a correct one. The access grant is probed by changing the sleep warning and the wake request one at a time, which shows which term gates it. All eight power-save codes are applied, which separates the three named modes from the fault class. RF-kill is toggled in both directions to confirm the synchronizer depth and that each change produces a pulse.

// File: rtl/hs_pkg.sv
package hs_pkg;

    localparam int REG_W     = 32;
    localparam int BIT_RDY   = 0;
    localparam int BIT_INIT  = 2;
    localparam int BIT_WAKE  = 3;
    localparam int BIT_SLEEP = 4;
    localparam int PS_LSB    = 24;
    localparam int PS_W      = 3;
    localparam int BIT_RFK   = 27;

    typedef enum logic [1:0] {
        PS_NONE       = 2'd0,
        PS_MAC_DOWN   = 2'd1,
        PS_RADIO_DOWN = 2'd2,
        PS_FAULT      = 2'd3
    } ps_kind_e;

    typedef struct packed {
        logic wake;
        logic init;
    } host_ctl_t;

    typedef struct packed {
        logic            rfk;
        logic [PS_W-1:0] ps;
        logic            sleep;
        logic            rdy;
    } live_stat_t;

    function automatic ps_kind_e decode_ps(input logic [PS_W-1:0] code);
        case (code)
            3'b000:  return PS_NONE;
            3'b001:  return PS_MAC_DOWN;
            3'b010:  return PS_RADIO_DOWN;
            default: return PS_FAULT;
        endcase
    endfunction

    function automatic logic [REG_W-1:0] pack_word(input host_ctl_t c, input live_stat_t s);
        logic [REG_W-1:0] w;
        w                        = '0;
        w[BIT_RDY]               = s.rdy;
        w[BIT_INIT]              = c.init;
        w[BIT_WAKE]              = c.wake;
        w[BIT_SLEEP]             = s.sleep;
        w[PS_LSB +: PS_W]        = s.ps;
        w[BIT_RFK]               = s.rfk;
        return w;
    endfunction

endpackage

// File: rtl/hs_ready_timer.sv
module hs_ready_timer #(
    parameter int READY_DLY = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic ack,
    output logic ready
);
    localparam int EFF_DLY = (READY_DLY < 1) ? 1 : READY_DLY;
    localparam int CW      = $clog2(EFF_DLY + 1);
    localparam logic [CW-1:0] LIMIT = CW'(EFF_DLY);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !enable || !ack) begin
            cnt <= '0;
        end else if (cnt != LIMIT) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign ready = enable && ack && (cnt == LIMIT);

    // R6: ready never shown without the acknowledge
    a_r6_ready_needs_ack: assert property (@(posedge clk) disable iff (rst)
        ready |-> ack);

    // R4: ready never shown before init-done
    a_r4_ready_needs_init: assert property (@(posedge clk) disable iff (rst)
        ready |-> enable);

    // R5: a rise of ready follows a cycle where the acknowledge was present
    a_r5_rise_after_ack: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> $past(ack));

endmodule

// File: rtl/hs_rfkill_sync.sv
module hs_rfkill_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic level,
    output logic change
);
    localparam int NS = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

    logic [NS-1:0] chain;
    logic          prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            prev  <= 1'b0;
        end else begin
            chain <= {chain[NS-2:0], pin};
            prev  <= chain[NS-1];
        end
    end

    assign level  = chain[NS-1];
    assign change = chain[NS-1] ^ prev;

endmodule

// File: rtl/hs_wake_ctrl.sv
module hs_wake_ctrl
    import hs_pkg::*;
#(
    parameter int READY_DLY   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  rd_data,
    output logic              pwr_req,
    input  logic              pwr_ack,
    input  logic              sleep_pending,
    input  logic [PS_W-1:0]   ps_mode,
    output logic [1:0]        ps_kind,
    input  logic              rfkill_pin,
    output logic              rfkill_event,
    output logic              access_ok
);
    host_ctl_t  ctl;
    live_stat_t stat;
    logic       clk_rdy;
    logic       rfk_level;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= '0;
        end else if (wr_en) begin
            ctl.wake <= wr_data[BIT_WAKE];
            ctl.init <= wr_data[BIT_INIT];
        end
    end

    assign pwr_req = ctl.wake | ctl.init;

    hs_ready_timer #(.READY_DLY(READY_DLY)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .enable (ctl.init),
        .ack    (pwr_ack),
        .ready  (clk_rdy)
    );

    hs_rfkill_sync #(.SYNC_STAGES(SYNC_STAGES)) u_rfk (
        .clk    (clk),
        .rst    (rst),
        .pin    (rfkill_pin),
        .level  (rfk_level),
        .change (rfkill_event)
    );

    always_comb begin
        stat.rdy   = clk_rdy;
        stat.sleep = sleep_pending;
        stat.ps    = ps_mode;
        stat.rfk   = rfk_level;
    end

    assign rd_data   = pack_word(ctl, stat);
    assign ps_kind   = decode_ps(ps_mode);
    assign access_ok = clk_rdy & ~sleep_pending & ctl.wake;

    // R7: a grant implies the domain is requested and acknowledged
    a_r7_grant_needs_handshake: assert property (@(posedge clk) disable iff (rst)
        access_ok |-> (pwr_req && pwr_ack && !sleep_pending));

    // R8: any code with the top bit set falls in the fault class
    a_r8_high_code_is_fault: assert property (@(posedge clk) disable iff (rst)
        ps_mode[2] |-> (ps_kind == 2'd3));

    // R10: an event coincides with a change of the reported switch bit
    a_r10_event_on_bit_change: assert property (@(posedge clk) disable iff (rst)
        rfkill_event |-> (rd_data[BIT_RFK] != $past(rd_data[BIT_RFK])));

endmodule

// File: tb/test_hs_wake_ctrl.sv
`timescale 1ns/1ps
module test_hs_wake_ctrl;

    localparam int DLY = 4;

    typedef struct {
        int          sel;
        logic [31:0] mask;
        logic [31:0] val;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        pwr_req;
    logic        pwr_ack = 1'b0;
    logic        sleep_pending = 1'b0;
    logic [2:0]  ps_mode = '0;
    logic [1:0]  ps_kind;
    logic        rfkill_pin = 1'b0;
    logic        rfkill_event;
    logic        access_ok;

    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;
    exp_t q[$];

    always #2.5 clk = ~clk;

    hs_wake_ctrl #(.READY_DLY(DLY), .SYNC_STAGES(2)) i_hs_wake_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .pwr_req(pwr_req), .pwr_ack(pwr_ack), .sleep_pending(sleep_pending),
        .ps_mode(ps_mode), .ps_kind(ps_kind), .rfkill_pin(rfkill_pin),
        .rfkill_event(rfkill_event), .access_ok(access_ok)
    );

    // sel: 0 rd_data, 1 pwr_req, 2 access_ok, 3 ps_kind, 4 rfkill_event
    function automatic logic [31:0] observe(int sel);
        case (sel)
            0: return rd_data;
            1: return {31'd0, pwr_req};
            2: return {31'd0, access_ok};
            3: return {30'd0, ps_kind};
            default: return {31'd0, rfkill_event};
        endcase
    endfunction

    always @(negedge clk) begin
        while (q.size() > 0) begin
            exp_t e;
            logic [31:0] act;
            e   = q.pop_front();
            act = observe(e.sel) & e.mask;
            n_cmp++;
            if (act !== (e.val & e.mask)) begin
                n_bad++;
                $display("FAIL %s: actual %h expected %h", e.tag, act, e.val & e.mask);
            end
        end
    end

    task automatic push(int sel, logic [31:0] mask, logic [31:0] val, string tag);
        exp_t e;
        e.sel = sel; e.mask = mask; e.val = val; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(logic [31:0] v);
        wr_en = 1'b1; wr_data = v;
        tick(1);
        wr_en = 1'b0; wr_data = '0;
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            n_bad++; n_cmp++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst = 1'b0;
        tick(1);
        // R1 reset state
        push(0, 32'hFFFF_FFFF, 32'h0, "R1 rd_data");
        push(1, 32'h1, 32'h0, "R1 pwr_req");
        push(2, 32'h1, 32'h0, "R1 access_ok");
        push(4, 32'h1, 32'h0, "R1 rfkill_event");
        tick(1);

        // R4: ack and wake without init-done
        pwr_ack = 1'b1;
        wr(32'h8);
        push(1, 32'h1, 32'h1, "R3 wake raises pwr_req");
        push(0, 32'hFFFF_FFFF, 32'h8, "R2 wake bit readback");
        tick(DLY + 4);
        push(0, 32'h1, 32'h0, "R4 no ready without init");
        push(2, 32'h1, 32'h0, "R4 no grant without init");

        // R2: ones everywhere except bits 3 and 2
        wr(32'hFFFF_FFF3);
        push(0, 32'hFFFF_FFFF, 32'h0, "R2 other bits ignored");
        push(1, 32'h1, 32'h0, "R3 both clear drops pwr_req");

        // R5: init-done while ack already held
        wr(32'hC);
        tick(DLY - 1);
        push(0, 32'h1, 32'h0, "R5 ready not early");
        tick(1);
        push(0, 32'hFFFF_FFFF, 32'hD, "R5 ready at count");
        push(2, 32'h1, 32'h1, "R7 grant all terms");

        // R7: sleep warning blocks grant
        tick(1);
        sleep_pending = 1'b1;
        push(2, 32'h1, 32'h0, "R7 sleep blocks grant");
        push(0, 32'h10, 32'h10, "R7 sleep bit mirror");
        tick(1);
        sleep_pending = 1'b0;
        wr(32'h4);
        push(2, 32'h1, 32'h0, "R7 no wake no grant");
        push(1, 32'h1, 32'h1, "R3 init alone holds pwr_req");
        push(0, 32'h1, 32'h1, "R7 ready kept with init");

        // R6: ack drop clears ready in the same cycle
        tick(1);
        pwr_ack = 1'b0;
        push(0, 32'h1, 32'h0, "R6 ready falls with ack");
        tick(1);
        pwr_ack = 1'b1;
        tick(DLY - 1);
        push(0, 32'h1, 32'h0, "R5 recount not early");
        tick(1);
        push(0, 32'h1, 32'h1, "R5 recount reaches ready");

        wr(32'h0);
        push(1, 32'h1, 32'h0, "R3 clear drops pwr_req");
        push(0, 32'h1, 32'h0, "R4 clearing init drops ready");

        // R8: all power-save codes
        for (int v = 0; v < 8; v++) begin
            tick(1);
            ps_mode = 3'(v);
            push(3, 32'h3, (v < 3) ? v : 3, "R8 ps_kind decode");
            push(0, 32'h0700_0000, 32'(v) << 24, "R8 ps field mirror");
        end
        tick(1);
        ps_mode = 3'd0;

        // R9/R10 rising switch
        rfkill_pin = 1'b1;
        tick(1);
        push(0, 32'h0800_0000, 32'h0, "R9 not after one edge");
        push(4, 32'h1, 32'h0, "R10 no early event");
        tick(1);
        push(0, 32'h0800_0000, 32'h0800_0000, "R9 after two edges");
        push(4, 32'h1, 32'h1, "R10 event on rise");
        tick(1);
        push(4, 32'h1, 32'h0, "R10 single cycle pulse");
        push(0, 32'h0800_0000, 32'h0800_0000, "R9 level held");

        // falling switch
        tick(2);
        rfkill_pin = 1'b0;
        tick(2);
        push(0, 32'h0800_0000, 32'h0, "R9 falls after two edges");
        push(4, 32'h1, 32'h1, "R10 event on fall");
        tick(1);
        push(4, 32'h1, 32'h0, "R10 fall pulse ends");

        tick(2);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule